// File: doc/BRIEF.md
# DDR Bank Command Timing Monitor

This block watches the decoded command stream of a four-bank double-data-rate DRAM. It reports every command that arrives before its minimum spacing has elapsed. Each cycle it takes a command code, a bank number, the auto-precharge bit and a pulse that marks the last beat of write data. All minimum spacings are parameters counted in clock cycles.

For each bank it tracks whether a row is open, along with the cycles elapsed since that bank's last activate, its last close and its last write data. It also keeps shared timers for the spacing between activates, for column-command spacing, for write-to-read turnaround and for the refresh busy window. The block is a passive monitor. Every command, including one that breaks a rule, updates the tracked state as if the device had accepted it.

A breach raises a one-cycle flag together with a code that names the rule. Both are registered and appear in the cycle after the offending command. When one command breaks several rules, a fixed priority picks the single code that is reported.

Top module: `ddr_cmd_timing_chk`

## Requirements
- R1: Command encoding on `cmd`: 0 idle, 1 activate, 2 read, 3 write, 4 precharge bank, 5 precharge all, 6 auto-refresh, 7 mode register set. `viol` and `viol_code` are registered and reflect the command of the previous cycle. `viol` is high exactly when `viol_code` is nonzero. Both are 0 after reset and after an idle command.
- R2: An activate to a bank fewer than T_RC cycles after that bank's previous activate gives code 4.
- R3: An activate fewer than T_RRD cycles after an activate to a different bank gives code 5.
- R4: An activate fewer than T_RP cycles after its bank was closed gives code 6. A bank is closed by a precharge, by a precharge-all, or by a read with `ap`=1 (closed at the read). Each of these must find the bank open to have any effect.
- R5: A write with `ap`=1 closes its bank in the cycle of its last data. An activate to that bank fewer than T_DAL cycles later gives code 7.
- R6: A read fewer than T_RCDRD cycles after its bank's activate gives code 8. A write fewer than T_RCDWR cycles after it gives code 9.
- R7: A precharge or precharge-all that finds an open bank whose activate is fewer than T_RAS cycles old gives code 10. A precharge to an idle bank has no effect on any timer.
- R8: A precharge or precharge-all reaching an open bank gives code 11 if a write burst to that bank is still in progress or its last data is fewer than T_WR cycles old.
- R9: A read while a write burst is in progress (write seen, last data not yet seen) gives code 13. A read fewer than T_CDLR cycles after the last write data gives code 12.
- R10: A read or write fewer than T_CCD cycles after the previous read or write gives code 14.
- R11: A read or write to a bank with no open row gives code 3.
- R12: Auto-refresh or mode register set with any bank open gives code 2. Any non-idle command fewer than T_RFC cycles after an auto-refresh gives code 1.
- R13: Code 1 overrides all others. For an activate the order is 4, 5, 6, 7. For a read it is 3, 13, 12, 8, 14. For a write it is 3, 9, 14. For a precharge it is 10, then 11. A violating command still updates all tracked state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Decoded command code |
| bank | input | BW (2) | Bank addressed by the command |
| ap | input | 1 | Auto-precharge bit of a read or write |
| wr_last | input | 1 | Last data beat of the current write burst |
| viol | output | 1 | Registered violation pulse |
| viol_code | output | 4 | Registered rule code, 0 when none |

## Verification
The bench targets commands placed exactly one cycle before and at each limit. A counter that is off by one would flag a legal command or miss the last illegal one.

It also drives commands that break several rules at once, such as an activate that is both too soon on its own bank and too close to another bank. A wrong priority chain would then report the wrong code.

Write bursts with auto-precharge, reads landing inside a burst, and precharges aimed at idle banks test the state bookkeeping. A design that closed the bank at the write command, or that let an idle-bank precharge restart the precharge timer, would flag later activates wrongly.

Refresh windows are checked against every command type.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_REF  = 3'd6,
    CMD_MRS  = 3'd7
  } cmd_e;

  typedef enum logic [3:0] {
    V_NONE      = 4'd0,
    V_RFC       = 4'd1,
    V_NOT_IDLE  = 4'd2,
    V_BANK_IDLE = 4'd3,
    V_RC        = 4'd4,
    V_RRD       = 4'd5,
    V_RP        = 4'd6,
    V_DAL       = 4'd7,
    V_RCD_RD    = 4'd8,
    V_RCD_WR    = 4'd9,
    V_RAS       = 4'd10,
    V_WR_REC    = 4'd11,
    V_CDLR      = 4'd12,
    V_WR_INTR   = 4'd13,
    V_CCD       = 4'd14
  } viol_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dct_since.sv
// Saturating count of cycles since the last load pulse.
module dct_since #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '1;
    else if (load)          cnt <= W'(1);
    else if (cnt != '1)     cnt <= cnt + W'(1);
  end

  // R2
  since_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    cnt != '0);

endmodule

// File: rtl/dct_bank.sv
// Open/closed state and elapsed-time counters of one bank.
module dct_bank
  import dct_pkg::*;
#(
  parameter int CW      = 6,
  parameter int T_RC    = 15,
  parameter int T_RAS   = 10,
  parameter int T_RCDRD = 5,
  parameter int T_RCDWR = 3,
  parameter int T_RP    = 5,
  parameter int T_WR    = 3,
  parameter int T_DAL   = 8
) (
  input  logic clk,
  input  logic rst,
  input  cmd_e cmd,
  input  logic sel,
  input  logic ap,
  input  logic wend,
  input  logic wend_ap,
  output logic active,
  output logic rc_ok,
  output logic ras_ok,
  output logic rcdrd_ok,
  output logic rcdwr_ok,
  output logic rp_ok,
  output logic wr_ok,
  output logic dal_ok
);

  logic          act_load, close, wclose;
  logic [CW-1:0] c_act, c_pre, c_wr, c_dal;

  assign act_load = sel && (cmd == CMD_ACT);
  assign close    = active && ((sel && cmd == CMD_PRE) || (cmd == CMD_PREA) ||
                               (sel && cmd == CMD_RD && ap));
  assign wclose   = wend && wend_ap;

  always_ff @(posedge clk) begin
    if (rst)                  active <= 1'b0;
    else if (act_load)        active <= 1'b1;
    else if (close || wclose) active <= 1'b0;
  end

  dct_since #(.W(CW)) u_act (.clk(clk), .rst(rst), .load(act_load), .cnt(c_act));
  dct_since #(.W(CW)) u_pre (.clk(clk), .rst(rst), .load(close),    .cnt(c_pre));
  dct_since #(.W(CW)) u_wr  (.clk(clk), .rst(rst), .load(wend),     .cnt(c_wr));
  dct_since #(.W(CW)) u_dal (.clk(clk), .rst(rst), .load(wclose),   .cnt(c_dal));

  assign rc_ok    = c_act >= CW'(T_RC);
  assign ras_ok   = c_act >= CW'(T_RAS);
  assign rcdrd_ok = c_act >= CW'(T_RCDRD);
  assign rcdwr_ok = c_act >= CW'(T_RCDWR);
  assign rp_ok    = c_pre >= CW'(T_RP);
  assign wr_ok    = c_wr  >= CW'(T_WR);
  assign dal_ok   = c_dal >= CW'(T_DAL);

  // R4
  close_restarts_rp_chk: assert property (@(posedge clk) disable iff (rst)
    close |=> (c_pre == CW'(1)) && !active);

  // R5
  ap_write_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (wclose && !act_load) |=> !active && (c_dal == CW'(1)));

endmodule

// File: rtl/dct_global.sv
// Timers shared across banks: activate spacing, column spacing,
// write turnaround, refresh window, and write-burst tracking.
module dct_global
  import dct_pkg::*;
#(
  parameter int BW     = 2,
  parameter int CW     = 6,
  parameter int T_RRD  = 4,
  parameter int T_CDLR = 2,
  parameter int T_CCD  = 1,
  parameter int T_RFC  = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  cmd_e          cmd,
  input  logic [BW-1:0] bank,
  input  logic          ap,
  input  logic          wr_last,
  output logic          rrd_ok,
  output logic          cdlr_ok,
  output logic          ccd_ok,
  output logic          rfc_ok,
  output logic          wr_busy,
  output logic [BW-1:0] wr_bank,
  output logic          wr_ap,
  output logic          wr_end
);

  logic [CW-1:0] c_act, c_col, c_wd, c_rfc;
  logic [BW-1:0] last_bank;
  logic          is_act, is_col;

  assign is_act = (cmd == CMD_ACT);
  assign is_col = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign wr_end = wr_last && wr_busy;

  dct_since #(.W(CW)) u_act (.clk(clk), .rst(rst), .load(is_act),          .cnt(c_act));
  dct_since #(.W(CW)) u_col (.clk(clk), .rst(rst), .load(is_col),          .cnt(c_col));
  dct_since #(.W(CW)) u_wd  (.clk(clk), .rst(rst), .load(wr_end),          .cnt(c_wd));
  dct_since #(.W(CW)) u_rfc (.clk(clk), .rst(rst), .load(cmd == CMD_REF),  .cnt(c_rfc));

  always_ff @(posedge clk) begin
    if (rst) begin
      last_bank <= '0;
      wr_busy   <= 1'b0;
      wr_bank   <= '0;
      wr_ap     <= 1'b0;
    end else begin
      if (is_act) last_bank <= bank;
      if (cmd == CMD_WR) begin
        wr_busy <= 1'b1;
        wr_bank <= bank;
        wr_ap   <= ap;
      end else if (wr_end) begin
        wr_busy <= 1'b0;
      end
    end
  end

  assign rrd_ok  = (last_bank == bank) || (c_act >= CW'(T_RRD));
  assign cdlr_ok = c_wd  >= CW'(T_CDLR);
  assign ccd_ok  = c_col >= CW'(T_CCD);
  assign rfc_ok  = c_rfc >= CW'(T_RFC);

  // R9
  burst_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_busy) |-> $past(wr_last));

  // R9
  burst_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_busy) |-> $past(cmd == CMD_WR));

endmodule

// File: rtl/dct_rules.sv
// Priority rule evaluation and the registered report.
module dct_rules
  import dct_pkg::*;
#(
  parameter int NB = 4,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  cmd_e          cmd,
  input  logic [BW-1:0] bank,
  input  logic [NB-1:0] active,
  input  logic [NB-1:0] rc_ok,
  input  logic [NB-1:0] ras_ok,
  input  logic [NB-1:0] rcdrd_ok,
  input  logic [NB-1:0] rcdwr_ok,
  input  logic [NB-1:0] rp_ok,
  input  logic [NB-1:0] wr_ok,
  input  logic [NB-1:0] dal_ok,
  input  logic          rrd_ok,
  input  logic          cdlr_ok,
  input  logic          ccd_ok,
  input  logic          rfc_ok,
  input  logic          wr_busy,
  input  logic [BW-1:0] wr_bank,
  output logic          viol,
  output logic [3:0]    viol_code
);

  logic [NB-1:0] wblk;
  viol_e         code_d;

  always_comb begin
    for (int b = 0; b < NB; b++)
      wblk[b] = !wr_ok[b] || (wr_busy && (wr_bank == BW'(b)));
  end

  always_comb begin
    code_d = V_NONE;
    case (cmd)
      CMD_ACT: begin
        if      (!rc_ok[bank])  code_d = V_RC;
        else if (!rrd_ok)       code_d = V_RRD;
        else if (!rp_ok[bank])  code_d = V_RP;
        else if (!dal_ok[bank]) code_d = V_DAL;
      end
      CMD_RD: begin
        if      (!active[bank])   code_d = V_BANK_IDLE;
        else if (wr_busy)         code_d = V_WR_INTR;
        else if (!cdlr_ok)        code_d = V_CDLR;
        else if (!rcdrd_ok[bank]) code_d = V_RCD_RD;
        else if (!ccd_ok)         code_d = V_CCD;
      end
      CMD_WR: begin
        if      (!active[bank])   code_d = V_BANK_IDLE;
        else if (!rcdwr_ok[bank]) code_d = V_RCD_WR;
        else if (!ccd_ok)         code_d = V_CCD;
      end
      CMD_PRE: begin
        if (active[bank]) begin
          if      (!ras_ok[bank]) code_d = V_RAS;
          else if (wblk[bank])    code_d = V_WR_REC;
        end
      end
      CMD_PREA: begin
        if      (|(active & ~ras_ok)) code_d = V_RAS;
        else if (|(active & wblk))    code_d = V_WR_REC;
      end
      CMD_REF, CMD_MRS: begin
        if (|active) code_d = V_NOT_IDLE;
      end
      default: code_d = V_NONE;
    endcase
    if ((cmd != CMD_NOP) && !rfc_ok) code_d = V_RFC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol      <= 1'b0;
      viol_code <= 4'd0;
    end else begin
      viol      <= (code_d != V_NONE);
      viol_code <= code_d;
    end
  end

  // R1
  flag_matches_code_chk: assert property (@(posedge clk) disable iff (rst)
    viol == (viol_code != 4'd0));

  // R1
  idle_cmd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd) == CMD_NOP) |-> !viol);

  // R11
  idle_bank_col_chk: assert property (@(posedge clk) disable iff (rst)
    (viol_code == 4'd3) |-> ($past(cmd) == CMD_RD || $past(cmd) == CMD_WR));

  // R12
  not_idle_only_ref_mrs_chk: assert property (@(posedge clk) disable iff (rst)
    (viol_code == 4'd2) |-> ($past(cmd) == CMD_REF || $past(cmd) == CMD_MRS));

endmodule

// File: rtl/ddr_cmd_timing_chk.sv
module ddr_cmd_timing_chk
  import dct_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RC      = 15,
  parameter int T_RFC     = 17,
  parameter int T_RAS     = 10,
  parameter int T_RCDRD   = 5,
  parameter int T_RCDWR   = 3,
  parameter int T_RP      = 5,
  parameter int T_RRD     = 4,
  parameter int T_WR      = 3,
  parameter int T_CDLR    = 2,
  parameter int T_CCD     = 1,
  parameter int T_DAL     = 8,
  localparam int BW       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    cmd,
  input  logic [BW-1:0] bank,
  input  logic          ap,
  input  logic          wr_last,
  output logic          viol,
  output logic [3:0]    viol_code
);

  localparam int TMAX = max2(max2(max2(T_RC, T_RFC), max2(T_RAS, T_DAL)),
                        max2(max2(max2(T_RCDRD, T_RCDWR), max2(T_RP, T_RRD)),
                             max2(max2(T_WR, T_CDLR), T_CCD)));
  localparam int CW   = $clog2(TMAX + 1) + 1;

  cmd_e cmd_t;
  assign cmd_t = cmd_e'(cmd);

  logic [NUM_BANKS-1:0] act_v, rc_ok, ras_ok, rcdrd_ok, rcdwr_ok, rp_ok, wr_ok, dal_ok;
  logic                 rrd_ok, cdlr_ok, ccd_ok, rfc_ok, wr_busy, wr_ap, wr_end;
  logic [BW-1:0]        wr_bank;

  dct_global #(
    .BW(BW), .CW(CW), .T_RRD(T_RRD), .T_CDLR(T_CDLR), .T_CCD(T_CCD), .T_RFC(T_RFC)
  ) u_glob (
    .clk(clk), .rst(rst), .cmd(cmd_t), .bank(bank), .ap(ap), .wr_last(wr_last),
    .rrd_ok(rrd_ok), .cdlr_ok(cdlr_ok), .ccd_ok(ccd_ok), .rfc_ok(rfc_ok),
    .wr_busy(wr_busy), .wr_bank(wr_bank), .wr_ap(wr_ap), .wr_end(wr_end)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    dct_bank #(
      .CW(CW), .T_RC(T_RC), .T_RAS(T_RAS), .T_RCDRD(T_RCDRD), .T_RCDWR(T_RCDWR),
      .T_RP(T_RP), .T_WR(T_WR), .T_DAL(T_DAL)
    ) u_bank (
      .clk(clk), .rst(rst), .cmd(cmd_t),
      .sel(bank == BW'(g)), .ap(ap),
      .wend(wr_end && (wr_bank == BW'(g))), .wend_ap(wr_ap),
      .active(act_v[g]), .rc_ok(rc_ok[g]), .ras_ok(ras_ok[g]),
      .rcdrd_ok(rcdrd_ok[g]), .rcdwr_ok(rcdwr_ok[g]), .rp_ok(rp_ok[g]),
      .wr_ok(wr_ok[g]), .dal_ok(dal_ok[g])
    );
  end

  dct_rules #(.NB(NUM_BANKS), .BW(BW)) u_rules (
    .clk(clk), .rst(rst), .cmd(cmd_t), .bank(bank),
    .active(act_v), .rc_ok(rc_ok), .ras_ok(ras_ok), .rcdrd_ok(rcdrd_ok),
    .rcdwr_ok(rcdwr_ok), .rp_ok(rp_ok), .wr_ok(wr_ok), .dal_ok(dal_ok),
    .rrd_ok(rrd_ok), .cdlr_ok(cdlr_ok), .ccd_ok(ccd_ok), .rfc_ok(rfc_ok),
    .wr_busy(wr_busy), .wr_bank(wr_bank),
    .viol(viol), .viol_code(viol_code)
  );

  // R12
  ref_window_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd_t) == CMD_REF) && ($past(cmd_t, 2) == CMD_REF) && !$past(rst, 2) |-> viol);

endmodule

// File: tb/sim_ddr_cmd_timing_chk.sv
`timescale 1ns/1ps
module sim_ddr_cmd_timing_chk;

  localparam int BT_RC = 15, BT_RFC = 17, BT_RAS = 10, BT_RCDRD = 5, BT_RCDWR = 3;
  localparam int BT_RP = 5, BT_RRD = 4, BT_WR = 3, BT_CDLR = 2, BT_CCD = 2, BT_DAL = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cmd_i = 3'd0;
  logic [1:0] bank_i = 2'd0;
  logic       ap_i = 1'b0;
  logic       wl_i = 1'b0;
  logic       viol;
  logic [3:0] viol_code;

  always #2 clk = ~clk;

  ddr_cmd_timing_chk #(.T_CCD(BT_CCD)) u0 (
    .clk(clk), .rst(rst), .cmd(cmd_i), .bank(bank_i), .ap(ap_i), .wr_last(wl_i),
    .viol(viol), .viol_code(viol_code)
  );

  int vectors = 0, fails = 0;
  bit done = 0;

  // reference model state (timestamps in cycles)
  int now;
  int t_act[4], t_pre[4], t_wend[4], t_dal[4];
  bit open_b[4];
  int t_any, lastb, t_col, t_wd, t_rfc;
  bit wbusy, wap;
  int wbank;

  bit         have_exp = 0;
  logic [3:0] exp_code;
  string      exp_tag;

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'd0:        return "R1";
      4'd1, 4'd2:  return "R12";
      4'd3:        return "R11";
      4'd4:        return "R2";
      4'd5:        return "R3";
      4'd6:        return "R4";
      4'd7:        return "R5";
      4'd8, 4'd9:  return "R6";
      4'd10:       return "R7";
      4'd11:       return "R8";
      4'd12, 4'd13: return "R9";
      default:     return "R10";
    endcase
  endfunction

  function automatic bit wblk(input int k);
    return ((now - t_wend[k]) < BT_WR) || (wbusy && wbank == k);
  endfunction

  task automatic check_out();
    vectors++;
    if (viol !== (exp_code != 0) || viol_code !== exp_code) begin
      fails++;
      $display("FAIL %s: viol=%0b code=%0d expected viol=%0b code=%0d",
               exp_tag, viol, viol_code, (exp_code != 0), exp_code);
    end
  endtask

  task automatic step(input int c, input int b, input bit a, input bit wl, input string tg);
    logic [3:0] e;
    bit wend, oa;
    int ob;
    @(negedge clk);
    if (have_exp) check_out();
    cmd_i = 3'(c); bank_i = 2'(b); ap_i = a; wl_i = wl;
    e = 0;
    case (c)
      1: begin
        if      (now - t_act[b] < BT_RC)               e = 4;
        else if (lastb != b && now - t_any < BT_RRD)   e = 5;
        else if (now - t_pre[b] < BT_RP)               e = 6;
        else if (now - t_dal[b] < BT_DAL)              e = 7;
      end
      2: begin
        if      (!open_b[b])                 e = 3;
        else if (wbusy)                      e = 13;
        else if (now - t_wd < BT_CDLR)       e = 12;
        else if (now - t_act[b] < BT_RCDRD)  e = 8;
        else if (now - t_col < BT_CCD)       e = 14;
      end
      3: begin
        if      (!open_b[b])                 e = 3;
        else if (now - t_act[b] < BT_RCDWR)  e = 9;
        else if (now - t_col < BT_CCD)       e = 14;
      end
      4: begin
        if (open_b[b]) begin
          if      (now - t_act[b] < BT_RAS) e = 10;
          else if (wblk(b))                 e = 11;
        end
      end
      5: begin
        for (int k = 0; k < 4; k++)
          if (e == 0 && open_b[k] && (now - t_act[k] < BT_RAS)) e = 10;
        for (int k = 0; k < 4; k++)
          if (e == 0 && open_b[k] && wblk(k)) e = 11;
      end
      6, 7: begin
        for (int k = 0; k < 4; k++) if (open_b[k]) e = 2;
      end
      default: e = 0;
    endcase
    if (c != 0 && (now - t_rfc) < BT_RFC) e = 1;

    // state update, all from pre-command values
    wend = wl && wbusy; ob = wbank; oa = wap;
    for (int k = 0; k < 4; k++) begin
      bit cl, wc, ac;
      cl = open_b[k] && ((k == b && c == 4) || c == 5 || (k == b && c == 2 && a));
      wc = wend && ob == k && oa;
      ac = (c == 1 && k == b);
      if (cl) t_pre[k] = now;
      if (wend && ob == k) t_wend[k] = now;
      if (wc) t_dal[k] = now;
      if (ac) begin t_act[k] = now; open_b[k] = 1; end
      else if (cl || wc) open_b[k] = 0;
    end
    if (c == 1) begin t_any = now; lastb = b; end
    if (c == 2 || c == 3) t_col = now;
    if (c == 6) t_rfc = now;
    if (wend) t_wd = now;
    if (c == 3) begin wbusy = 1; wbank = b; wap = a; end
    else if (wend) wbusy = 0;

    exp_code = e;
    exp_tag  = (tg != "") ? tg : tag_of(e);
    have_exp = 1;
    now++;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, "");
  endtask

  initial begin
    int r;
    void'($urandom(32'd7411));
    now = 0;
    for (int k = 0; k < 4; k++) begin
      t_act[k] = -1000; t_pre[k] = -1000; t_wend[k] = -1000; t_dal[k] = -1000; open_b[k] = 0;
    end
    t_any = -1000; lastb = 0; t_col = -1000; t_wd = -1000; t_rfc = -1000;
    wbusy = 0; wap = 0; wbank = 0;

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_code = 0; exp_tag = "R1"; have_exp = 1; now = 1;  // reset state check

    // R6 activate-to-read and R10 column spacing
    step(1, 0, 0, 0, "");
    step(2, 0, 0, 0, "");
    nops(4);
    step(2, 0, 0, 0, "");
    step(2, 0, 0, 0, "");
    nops(2);
    // R13 activate too soon on own bank and near another bank
    step(1, 1, 0, 0, "");
    step(1, 0, 0, 0, "R13");
    // R6 write spacing, R9 read inside burst
    nops(3);
    step(3, 1, 0, 0, "");
    step(2, 1, 0, 0, "");
    step(0, 0, 0, 1, "");
    step(2, 1, 0, 0, "");
    nops(2);
    // R8 precharge inside write recovery
    step(3, 1, 0, 0, "");
    nops(3);
    step(0, 0, 0, 1, "");
    step(4, 1, 0, 0, "");
    nops(12);
    // R7 precharge to idle bank leaves timers alone
    step(4, 2, 0, 0, "R7");
    step(1, 2, 0, 0, "R7");
    nops(4);
    // R5 write with auto-precharge
    step(3, 2, 1, 0, "");
    nops(2);
    step(0, 0, 0, 1, "");
    nops(6);
    step(1, 2, 0, 0, "");
    nops(1);
    step(1, 2, 0, 0, "");
    // R11 column to idle bank
    step(2, 3, 0, 0, "");
    // R12 refresh with open banks, then within refresh window
    step(6, 0, 0, 0, "");
    nops(16);
    step(5, 0, 0, 0, "");
    nops(BT_RP + 20);
    step(6, 0, 0, 0, "");
    nops(BT_RFC - 2);
    step(7, 0, 0, 0, "");
    step(7, 0, 0, 0, "");
    // R4 read with auto-precharge then early activate
    step(1, 3, 0, 0, "");
    nops(BT_RCDRD);
    step(2, 3, 1, 0, "");
    nops(BT_RP - 2);
    step(1, 3, 0, 0, "");
    nops(20);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int c, b; bit a, wl;
      r = $urandom % 100;
      if      (r < 50) c = 0;
      else if (r < 65) c = 1;
      else if (r < 75) c = 2;
      else if (r < 85) c = 3;
      else if (r < 92) c = 4;
      else if (r < 95) c = 5;
      else if (r < 97) c = 6;
      else             c = 7;
      b  = $urandom % 4;
      a  = (($urandom % 10) < 3);
      wl = wbusy ? (($urandom % 10) < 3) : (($urandom % 100) < 3);
      step(c, b, a, wl, "");
    end
    step(0, 0, 0, 0, "");
    @(negedge clk);
    check_out();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: R1 run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule